// File: doc/BRIEF.md
# CAN Receive Acceptance Mask Filter

This block decides whether an incoming 29-bit extended CAN identifier is accepted by a set of receive filter entries. There are two kinds of entry: message-buffer identifier words and receive-FIFO format-A table entries. Each entry is compared against the identifier through an acceptance mask. Every mask bit governs one bit position of the filter word, and a cleared mask bit turns that position into a don't-care. All FIFO entries and most buffers use one shared global mask. Two designated buffers (14 and 15 by default) each have a dedicated mask with the same layout.

The identifier does not sit at the same place in the two layouts. A buffer word holds it in bits 28..0. A FIFO format-A entry holds it in bits 29..1, one position higher. Because the mask follows filter-word positions, one mask value can ignore identifier bit n on the buffer path and identifier bit n-1 on the FIFO path. The block shifts the identifier into each layout before it compares.

Matching is evaluated combinationally for all entries. The per-entry match flags, a hit flag and the lowest-numbered winning index for each path are registered on the identifier-valid strobe. They appear on the following cycle and are held until the next strobe.

Top module: `can_accept_filter`

## Requirements
- R1: Buffer entry k matches only if it is enabled and, for every bit position p in 28..0 whose mask bit is 1, filter-word bit p equals identifier bit p.
- R2: FIFO entry k matches only if it is enabled and, for every position p in 29..1 whose global-mask bit is 1, filter-word bit p equals identifier bit p-1 (the identifier is shifted left by one).
- R3: Buffer 14 is filtered through `mask14_i` and buffer 15 through `mask15_i`. Every other buffer and every FIFO entry uses `gmask_i`.
- R4: Filter-word and mask bits outside the identifier field have no effect on matching. These are bits 31..29 for buffers, and bits 31, 30 and 0 for FIFO entries.
- R5: An entry whose enable bit is 0 never reports a match, whatever its filter word.
- R6: When `id_valid_i` is high at clock edge n, `result_valid_o` is high after edge n+1 and carries the results for the inputs sampled at edge n. It is low after any edge at which `id_valid_i` was low. Back-to-back strobes give back-to-back results.
- R7: `mb_hit_o`/`fifo_hit_o` is 1 if any entry of that path matched. `mb_index_o`/`fifo_index_o` is the lowest-numbered matching entry, or 0 when nothing matched.
- R8: While `id_valid_i` is low, all match, hit and index outputs keep their values regardless of the other inputs.
- R9: During reset, all outputs are 0.
- R10: A global mask of 0xFFFF_FFEF (bit 4 cleared) makes identifier bit 4 a don't-care for buffers, and identifier bit 3 a don't-care for FIFO entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid_i | input | 1 | Identifier strobe, one cycle per identifier |
| id_i | input | 29 | Incoming extended identifier |
| gmask_i | input | 32 | Global acceptance mask, 1 = compare |
| mask14_i | input | 32 | Dedicated mask for the first designated buffer |
| mask15_i | input | 32 | Dedicated mask for the second designated buffer |
| mb_filter_i | input | NUM_MB*32 | Buffer identifier words, entry k at bits 32k+31..32k |
| mb_enable_i | input | NUM_MB | Buffer entry enables |
| fifo_filter_i | input | NUM_FIFO*32 | FIFO format-A entries, entry k at bits 32k+31..32k |
| fifo_enable_i | input | NUM_FIFO | FIFO entry enables |
| result_valid_o | output | 1 | Results refreshed this cycle |
| mb_match_o | output | NUM_MB | Per-buffer match flags |
| mb_hit_o | output | 1 | Any buffer matched |
| mb_index_o | output | clog2(NUM_MB) | Lowest matching buffer |
| fifo_match_o | output | NUM_FIFO | Per-FIFO-entry match flags |
| fifo_hit_o | output | 1 | Any FIFO entry matched |
| fifo_index_o | output | clog2(NUM_FIFO) | Lowest matching FIFO entry |

## Verification
The buffer path and the FIFO path evaluate the same identifier in the same cycle, under the same global mask bit, and then register together. The bench provokes this with a mask that has one cleared bit. It loads buffer and FIFO entries that differ from the identifier either at the masked position or one position away. It judges that one path hits and the other misses, exactly as the shifted layout predicts. A second overlap comes from the dedicated masks: the designated buffers and their neighbours share one strobe. The bench expects neighbours that hold identical filter words to disagree only because of the mask each one uses.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam int ID_W   = 29;
  localparam int WORD_W = 32;

  typedef enum logic {
    LAYOUT_BUF   = 1'b0,
    LAYOUT_FIFOA = 1'b1
  } layout_e;

  // place the identifier where the given layout stores it
  function automatic logic [WORD_W-1:0] align_id(input logic [ID_W-1:0] id,
                                                  input layout_e lay);
    logic [WORD_W-1:0] w;
    if (lay == LAYOUT_FIFOA) w = {{(WORD_W-ID_W-1){1'b0}}, id, 1'b0};
    else                     w = {{(WORD_W-ID_W){1'b0}}, id};
    return w;
  endfunction

  // filter-word positions that carry identifier bits in the given layout
  function automatic logic [WORD_W-1:0] id_field(input layout_e lay);
    logic [WORD_W-1:0] ones;
    ones = {{(WORD_W-ID_W){1'b0}}, {ID_W{1'b1}}};
    return (lay == LAYOUT_FIFOA) ? (ones << 1) : ones;
  endfunction

  // one entry: all compared positions equal, and entry enabled
  function automatic logic entry_hit(input logic [WORD_W-1:0] filt,
                                     input logic [WORD_W-1:0] aligned,
                                     input logic [WORD_W-1:0] mask,
                                     input logic [WORD_W-1:0] field,
                                     input logic              en);
    return en && (((filt ^ aligned) & mask & field) == '0);
  endfunction

endpackage

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
#(
  parameter int      N   = 16,
  parameter layout_e LAY = LAYOUT_BUF
) (
  input  logic [ID_W-1:0]     id,
  input  logic [N*WORD_W-1:0] masks,
  input  logic [N*WORD_W-1:0] filters,
  input  logic [N-1:0]        enables,
  output logic [N-1:0]        match
);

  localparam logic [WORD_W-1:0] FIELD = id_field(LAY);

  logic [WORD_W-1:0] aligned;
  assign aligned = align_id(id, LAY);

  for (genvar k = 0; k < N; k++) begin : g_entry
    assign match[k] = entry_hit(filters[k*WORD_W +: WORD_W], aligned,
                                masks[k*WORD_W +: WORD_W], FIELD, enables[k]);
  end

endmodule

// File: rtl/can_first_hit.sv
module can_first_hit #(
  parameter int N   = 16,
  parameter int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
  end

  assign any = |req;

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_MB   = 16,
  parameter int NUM_FIFO = 8,
  parameter int DED_A    = 14,
  parameter int DED_B    = 15,
  localparam int MB_IW   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int FF_IW   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       id_valid_i,
  input  logic [ID_W-1:0]            id_i,
  input  logic [WORD_W-1:0]          gmask_i,
  input  logic [WORD_W-1:0]          mask14_i,
  input  logic [WORD_W-1:0]          mask15_i,
  input  logic [NUM_MB*WORD_W-1:0]   mb_filter_i,
  input  logic [NUM_MB-1:0]          mb_enable_i,
  input  logic [NUM_FIFO*WORD_W-1:0] fifo_filter_i,
  input  logic [NUM_FIFO-1:0]        fifo_enable_i,
  output logic                       result_valid_o,
  output logic [NUM_MB-1:0]          mb_match_o,
  output logic                       mb_hit_o,
  output logic [MB_IW-1:0]           mb_index_o,
  output logic [NUM_FIFO-1:0]        fifo_match_o,
  output logic                       fifo_hit_o,
  output logic [FF_IW-1:0]           fifo_index_o
);

  // per-entry mask selection for the buffer path
  logic [NUM_MB*WORD_W-1:0] mb_mask_sel;
  for (genvar k = 0; k < NUM_MB; k++) begin : g_mbmask
    if (k == DED_A) begin : g_a
      assign mb_mask_sel[k*WORD_W +: WORD_W] = mask14_i;
    end else if (k == DED_B) begin : g_b
      assign mb_mask_sel[k*WORD_W +: WORD_W] = mask15_i;
    end else begin : g_g
      assign mb_mask_sel[k*WORD_W +: WORD_W] = gmask_i;
    end
  end

  logic [NUM_FIFO*WORD_W-1:0] ff_mask_sel;
  assign ff_mask_sel = {NUM_FIFO{gmask_i}};

  // combinational match events, named for the checker
  logic [NUM_MB-1:0]   mb_match_c;
  logic [NUM_FIFO-1:0] ff_match_c;
  logic                mb_any_c, ff_any_c;
  logic [MB_IW-1:0]    mb_idx_c;
  logic [FF_IW-1:0]    ff_idx_c;

  can_filt_bank #(.N(NUM_MB), .LAY(LAYOUT_BUF)) u_mb_bank (
    .id(id_i), .masks(mb_mask_sel), .filters(mb_filter_i),
    .enables(mb_enable_i), .match(mb_match_c)
  );

  can_filt_bank #(.N(NUM_FIFO), .LAY(LAYOUT_FIFOA)) u_ff_bank (
    .id(id_i), .masks(ff_mask_sel), .filters(fifo_filter_i),
    .enables(fifo_enable_i), .match(ff_match_c)
  );

  can_first_hit #(.N(NUM_MB), .IW(MB_IW)) u_mb_pick (
    .req(mb_match_c), .any(mb_any_c), .idx(mb_idx_c)
  );

  can_first_hit #(.N(NUM_FIFO), .IW(FF_IW)) u_ff_pick (
    .req(ff_match_c), .any(ff_any_c), .idx(ff_idx_c)
  );

  logic capture;
  assign capture = id_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid_o <= 1'b0;
      mb_match_o     <= '0;
      mb_hit_o       <= 1'b0;
      mb_index_o     <= '0;
      fifo_match_o   <= '0;
      fifo_hit_o     <= 1'b0;
      fifo_index_o   <= '0;
    end else begin
      result_valid_o <= capture;
      if (capture) begin
        mb_match_o   <= mb_match_c;
        mb_hit_o     <= mb_any_c;
        mb_index_o   <= mb_idx_c;
        fifo_match_o <= ff_match_c;
        fifo_hit_o   <= ff_any_c;
        fifo_index_o <= ff_idx_c;
      end
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NUM_MB   = 16,
  parameter int NUM_FIFO = 8,
  parameter int MB_IW    = 4,
  parameter int FF_IW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                id_valid_i,
  input logic [NUM_MB-1:0]   mb_enable_i,
  input logic [NUM_FIFO-1:0] fifo_enable_i,
  input logic                result_valid_o,
  input logic [NUM_MB-1:0]   mb_match_o,
  input logic                mb_hit_o,
  input logic [MB_IW-1:0]    mb_index_o,
  input logic [NUM_FIFO-1:0] fifo_match_o,
  input logic                fifo_hit_o,
  input logic [FF_IW-1:0]    fifo_index_o
);

  logic [NUM_MB-1:0]   mb_below;
  logic [NUM_FIFO-1:0] ff_below;
  assign mb_below = (NUM_MB'(1) << mb_index_o) - NUM_MB'(1);
  assign ff_below = (NUM_FIFO'(1) << fifo_index_o) - NUM_FIFO'(1);

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid_i |=> result_valid_o);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i |=> !result_valid_o);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i |=> ($stable(mb_match_o) && $stable(fifo_match_o) &&
                     $stable(mb_index_o) && $stable(fifo_index_o) &&
                     $stable(mb_hit_o) && $stable(fifo_hit_o)));

  // R7
  mb_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && mb_hit_o) |-> (mb_match_o[mb_index_o] && ((mb_match_o & mb_below) == '0)));

  // R7
  ff_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && fifo_hit_o) |-> (fifo_match_o[fifo_index_o] && ((fifo_match_o & ff_below) == '0)));

  // R7
  miss_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> ((mb_hit_o == (mb_match_o != '0)) && (fifo_hit_o == (fifo_match_o != '0)) &&
                        (mb_hit_o || mb_index_o == '0) && (fifo_hit_o || fifo_index_o == '0)));

  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid_i |=> (((mb_match_o & ~$past(mb_enable_i)) == '0) &&
                    ((fifo_match_o & ~$past(fifo_enable_i)) == '0)));

endmodule

bind can_accept_filter can_accept_filter_chk #(
  .NUM_MB(NUM_MB), .NUM_FIFO(NUM_FIFO), .MB_IW(MB_IW), .FF_IW(FF_IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid_i),
  .mb_enable_i(mb_enable_i), .fifo_enable_i(fifo_enable_i),
  .result_valid_o(result_valid_o), .mb_match_o(mb_match_o),
  .mb_hit_o(mb_hit_o), .mb_index_o(mb_index_o),
  .fifo_match_o(fifo_match_o), .fifo_hit_o(fifo_hit_o),
  .fifo_index_o(fifo_index_o)
);

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;

  localparam int NMB = 16;
  localparam int NFF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid = 1'b0;
  logic [28:0] id = '0;
  logic [31:0] gm = '0, m14 = '0, m15 = '0;
  logic [31:0] mb_f [NMB];
  logic [31:0] ff_f [NFF];
  logic [NMB-1:0] mb_en = '0;
  logic [NFF-1:0] ff_en = '0;
  logic [NMB*32-1:0] mb_pack;
  logic [NFF*32-1:0] ff_pack;

  logic            rv;
  logic [NMB-1:0]  mbm;
  logic            mbh;
  logic [3:0]      mbi;
  logic [NFF-1:0]  ffm;
  logic            ffh;
  logic [2:0]      ffi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NMB; k++) mb_pack[k*32 +: 32] = mb_f[k];
    for (int k = 0; k < NFF; k++) ff_pack[k*32 +: 32] = ff_f[k];
  end

  can_accept_filter u0 (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid), .id_i(id),
    .gmask_i(gm), .mask14_i(m14), .mask15_i(m15),
    .mb_filter_i(mb_pack), .mb_enable_i(mb_en),
    .fifo_filter_i(ff_pack), .fifo_enable_i(ff_en),
    .result_valid_o(rv), .mb_match_o(mbm), .mb_hit_o(mbh), .mb_index_o(mbi),
    .fifo_match_o(ffm), .fifo_hit_o(ffh), .fifo_index_o(ffi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent model, walked per identifier bit
  function automatic logic mb_exp(int k);
    logic [31:0] m;
    m = (k == 14) ? m14 : (k == 15) ? m15 : gm;
    if (!mb_en[k]) return 1'b0;
    for (int b = 0; b < 29; b++)
      if (m[b] && (mb_f[k][b] !== id[b])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic ff_exp(int k);
    if (!ff_en[k]) return 1'b0;
    for (int b = 0; b < 29; b++)
      if (gm[b+1] && (ff_f[k][b+1] !== id[b])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic compare(input string tag);
    logic [NMB-1:0] em;
    logic [NFF-1:0] ef;
    int ei, fi;
    em = '0; ef = '0; ei = -1; fi = -1;
    for (int k = 0; k < NMB; k++) begin
      em[k] = mb_exp(k);
      if (em[k] && ei < 0) ei = k;
    end
    for (int k = 0; k < NFF; k++) begin
      ef[k] = ff_exp(k);
      if (ef[k] && fi < 0) fi = k;
    end
    chk(rv === 1'b1, {tag, " valid R6"}, 32'(rv), 1);
    chk(mbm === em, {tag, " mb flags"}, 32'(mbm), 32'(em));
    chk(ffm === ef, {tag, " fifo flags"}, 32'(ffm), 32'(ef));
    chk(mbh === (ei >= 0) && mbi === 4'((ei < 0) ? 0 : ei), {tag, " mb pick R7"},
        {mbh, 27'd0, mbi}, {(ei >= 0), 27'd0, 4'((ei < 0) ? 0 : ei)});
    chk(ffh === (fi >= 0) && ffi === 3'((fi < 0) ? 0 : fi), {tag, " fifo pick R7"},
        {ffh, 28'd0, ffi}, {(fi >= 0), 28'd0, 3'((fi < 0) ? 0 : fi)});
  endtask

  task automatic strobe();
    @(negedge clk); id_valid = 1'b1;
    @(negedge clk); id_valid = 1'b0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < NMB; k++) mb_f[k] = 32'h0;
    for (int k = 0; k < NFF; k++) ff_f[k] = 32'h0;
    mb_en = '0; ff_en = '0;
    gm = 32'hFFFF_FFFF; m14 = 32'hFFFF_FFFF; m15 = 32'hFFFF_FFFF;
  endtask

  task automatic t_reset();
    chk(rv === 0 && mbm === 0 && mbh === 0 && mbi === 0 && ffm === 0 && ffh === 0 && ffi === 0,
        "R9 reset outputs", {rv, mbh, ffh, 29'(mbm)}, 0);
  endtask

  task automatic t_buf_exact();
    clear_all();
    id = 29'h0ABC_1234;
    mb_f[3] = {3'b000, id}; mb_f[4] = {3'b000, id ^ 29'h1}; mb_en = 16'h0018;
    strobe(); compare("R1 buffer exact");
    chk(mbm === 16'h0008, "R1 only entry 3", 32'(mbm), 32'h8);
  endtask

  task automatic t_fifo_shift();
    clear_all();
    id = 29'h1357_9BDF;
    ff_f[2] = {2'b00, id, 1'b0}; mb_f[2] = {2'b00, id, 1'b0};
    ff_f[5] = {3'b000, id};
    ff_en = 8'h24; mb_en = 16'h0004;
    strobe(); compare("R2 fifo shifted");
    chk(ffm === 8'h04 && mbm === 16'h0, "R2 layout separation", {ffm, 8'h0, mbm}, 32'h0400_0000);
  endtask

  task automatic t_mask_split();
    clear_all();
    gm = 32'hFFFF_FFEF;
    id = 29'h0F0F_0F0F;
    mb_f[0] = {3'b000, id ^ 29'h10};
    mb_f[1] = {3'b000, id ^ 29'h08};
    ff_f[0] = {2'b00, id ^ 29'h10, 1'b0};
    ff_f[1] = {2'b00, id ^ 29'h08, 1'b0};
    mb_en = 16'h0003; ff_en = 8'h03;
    strobe(); compare("R10 split mask");
    chk(mbm === 16'h0001 && ffm === 8'h02, "R10 buf ignores id4 fifo ignores id3",
        {ffm, 8'h0, mbm}, 32'h0200_0001);
  endtask

  task automatic t_dedicated();
    clear_all();
    m14 = ~32'h0000_0400; m15 = ~32'h0000_0800;
    id = 29'h1555_0000;
    for (int k = 12; k < 16; k++) mb_f[k] = {3'b000, id ^ 29'h400};
    ff_f[0] = {2'b00, id ^ 29'h200, 1'b0};
    mb_en = 16'hF000; ff_en = 8'h01;
    strobe(); compare("R3 dedicated a");
    chk(mbm === 16'h4000 && ffm === 8'h0, "R3 only buffer 14", {ffm, 8'h0, mbm}, 32'h4000);
    for (int k = 12; k < 16; k++) mb_f[k] = {3'b000, id ^ 29'h800};
    strobe(); compare("R3 dedicated b");
    chk(mbm === 16'h8000 && mbi === 4'd15, "R3 only buffer 15", {mbi, 12'h0, mbm}, 32'hF000_8000);
  endtask

  task automatic t_outside();
    clear_all();
    id = 29'h1FFF_FFFE;
    mb_f[6] = {3'b111, id};
    ff_f[4] = {2'b11, id, 1'b1};
    mb_en = 16'h0040; ff_en = 8'h10;
    strobe(); compare("R4 outside field");
    chk(mbm === 16'h0040 && ffm === 8'h10, "R4 stray bits ignored", {ffm, 8'h0, mbm}, 32'h1000_0040);
  endtask

  task automatic t_disabled();
    clear_all();
    id = 29'h0123_4567;
    mb_f[7] = {3'b000, id}; ff_f[3] = {2'b00, id, 1'b0};
    strobe(); compare("R5 disabled");
    chk(mbh === 0 && ffh === 0 && mbm === 0 && ffm === 0, "R5 no match when off",
        {mbh, ffh, 30'(mbm)}, 0);
  endtask

  task automatic t_priority();
    clear_all();
    id = 29'h0AAA_5555;
    mb_f[2] = {3'b000, id}; mb_f[5] = {3'b000, id}; mb_f[9] = {3'b000, id};
    ff_f[3] = {2'b00, id, 1'b0}; ff_f[6] = {2'b00, id, 1'b0};
    mb_en = 16'hFFFF; ff_en = 8'hFF;
    strobe(); compare("R7 priority");
    chk(mbi === 4'd2 && ffi === 3'd3, "R7 lowest wins", {mbi, 25'd0, ffi}, {4'd2, 25'd0, 3'd3});
    mb_f[2] = 32'h0;
    strobe();
    chk(mbi === 4'd5, "R7 next lowest", 32'(mbi), 5);
    id = id ^ 29'h1;
    strobe(); compare("R7 no hit");
    chk(mbh === 0 && mbi === 0 && ffh === 0 && ffi === 0, "R7 miss index zero",
        {mbh, ffh, 26'd0, mbi}, 0);
  endtask

  task automatic t_hold();
    logic [NMB-1:0] m0; logic [NFF-1:0] f0; logic [3:0] i0; logic [2:0] j0;
    clear_all();
    id = 29'h0055_AA00;
    mb_f[1] = {3'b000, id}; ff_f[1] = {2'b00, id, 1'b0};
    mb_en = 16'h0002; ff_en = 8'h02;
    strobe(); compare("R8 setup");
    m0 = mbm; f0 = ffm; i0 = mbi; j0 = ffi;
    id = 29'h0; mb_f[0] = 32'h0; mb_en = 16'hFFFF; ff_en = 8'hFF; gm = 32'h0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(rv === 0, "R6 valid low when idle", 32'(rv), 0);
      chk(mbm === m0 && ffm === f0 && mbi === i0 && ffi === j0, "R8 outputs held",
          {ffm, 8'h0, mbm}, {f0, 8'h0, m0});
    end
  endtask

  task automatic t_back_to_back();
    clear_all();
    mb_f[8] = {3'b000, 29'h0000_0111}; mb_f[10] = {3'b000, 29'h0000_0222};
    mb_en = 16'h0500;
    @(negedge clk); id = 29'h111; id_valid = 1'b1;
    @(negedge clk); compare("R6 first of pair");
    chk(mbi === 4'd8, "R6 first result", 32'(mbi), 8);
    id = 29'h222;
    @(negedge clk); compare("R6 second of pair");
    chk(mbi === 4'd10, "R6 second result", 32'(mbi), 10);
    id_valid = 1'b0;
    @(negedge clk);
    chk(rv === 0, "R6 pulse ends", 32'(rv), 0);
  endtask

  initial begin
    clear_all();
    gm = '0; m14 = '0; m15 = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_buf_exact();
    t_fifo_shift();
    t_mask_split();
    t_dedicated();
    t_outside();
    t_disabled();
    t_priority();
    t_hold();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule